// File: doc/BRIEF.md
# Programmed A/D Converter Interface Controller

This block sits on a minicomputer's programmed I/O bus and controls one sampling analog-to-digital converter. It reacts only to I/O instructions that carry its device code. It holds an 8-bit analog channel register and the usual Busy and Done flags. The converter is driven through a start pulse. It answers with an end-of-conversion strobe and a data word, which the block captures for readback.

Software loads a channel number and issues a Start. The converter is launched either at once or on the next tick of a timebase. That timebase is either an internal divider or a synchronised external clock. When the conversion ends, the block latches the sample and advances the channel register by one. It then raises Done, which drives an interrupt request unless the interrupt mask bit is set. A program can scan consecutive channels by reissuing Start after each readback.

Top module: `adc_pio_ctrl`

## Requirements
- R1: Only instructions with `io_strb` high and `io_dev` equal to octal 21 have any effect or return data. For any other device code, `io_rdata` is zero and no state changes.
- R2: Operation code 2 (data-out A) loads `io_wdata[7:0]` into the channel register, and the upper byte is ignored. Operation code 1 (data-in A) returns the channel register on `io_rdata[7:0]`, with zero in `io_rdata[15:8]`.
- R3: Operation code 5 (data-in C) returns the 16-bit two's complement sample captured on the last accepted end-of-conversion strobe. The value is held unchanged until the next accepted strobe.
- R4: Function code 1 (Start) with Busy clear sets Busy and clears Done. When no timebase is enabled, `cv_start` is high for exactly one cycle on the clock edge after Busy sets.
- R5: A Start received while Busy is set is ignored. It produces no further `cv_start` pulse and leaves the flags unchanged.
- R6: Function code 2 (Clear) clears Busy and Done and abandons any conversion in flight. An end-of-conversion strobe arriving afterwards is ignored.
- R7: An end-of-conversion strobe accepted while a conversion is in flight clears Busy and sets Done. It also increments the channel register by one, wrapping from 255 to 0.
- R8: `int_req` equals Done unless the mask bit is set. The mask bit is loaded from `io_wdata[7]` on each `msk_strb` pulse, which is bit 8 counted from the most significant bit as 0.
- R9: `skp_idle` is high exactly when Busy is clear, and `skp_done` is high exactly when Done is set.
- R10: With `tb_int_en` high, a started conversion is launched only on an internal timebase tick. Ticks repeat every `tb_div` clock cycles, with zero treated as one.
- R11: With `tb_int_en` low and `tb_ext_en` high, a started conversion waits for a rising edge of `tb_ext_clk`. That edge passes through a two-stage synchroniser, and the launch follows it within four clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_strb | input | 1 | I/O instruction valid for one cycle |
| io_dev | input | 6 | Device code of the instruction |
| io_op | input | 3 | Transfer code (1 in-A, 2 out-A, 5 in-C) |
| io_fn | input | 2 | Control function (0 none, 1 Start, 2 Clear, 3 pulse) |
| io_wdata | input | 16 | Accumulator word sent to the device |
| io_rdata | output | 16 | Word returned to the accumulator during a read |
| msk_strb | input | 1 | Interrupt mask load strobe, mask word on `io_wdata` |
| int_req | output | 1 | Interrupt request |
| skp_idle | output | 1 | Busy flag is clear |
| skp_done | output | 1 | Done flag is set |
| tb_int_en | input | 1 | Gate launches with the internal timebase |
| tb_div | input | TB_W | Internal timebase period in clock cycles |
| tb_ext_en | input | 1 | Gate launches with the external clock |
| tb_ext_clk | input | 1 | Asynchronous external start clock |
| cv_start | output | 1 | Start-convert pulse to the converter |
| cv_eoc | input | 1 | End-of-conversion strobe from the converter |
| cv_data | input | 16 | Converted sample, valid with `cv_eoc` |

## Verification
The hardest case to reach is a conversion that is abandoned while the converter is still working. The bench issues Start and then Clear before the converter model returns its strobe. It then confirms that the late strobe changes neither Done, the channel register nor the held sample. Timebase gating is observed through the spacing of launches. The bench measures the cycle distance between two back-to-back conversions under the internal divider, and it holds the external clock low for a long stretch before producing an edge.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

    localparam logic [5:0] ADC_DEV_CODE = 6'o21;
    localparam int         MASK_BIT     = 7;

    typedef enum logic [2:0] {
        OP_NIO = 3'd0,
        OP_DIA = 3'd1,
        OP_DOA = 3'd2,
        OP_DIB = 3'd3,
        OP_DOB = 3'd4,
        OP_DIC = 3'd5,
        OP_DOC = 3'd6,
        OP_SKP = 3'd7
    } io_op_e;

    typedef enum logic [1:0] {
        FN_NONE  = 2'd0,
        FN_START = 2'd1,
        FN_CLEAR = 2'd2,
        FN_PULSE = 2'd3
    } io_fn_e;

    typedef struct packed {
        logic load_chan;
        logic rd_chan;
        logic rd_data;
        logic start;
        logic clear;
    } cmd_t;

    function automatic logic [15:0] chan_word(input logic [7:0] c);
        return {8'h00, c};
    endfunction

endpackage

// File: rtl/adcif_decode.sv
module adcif_decode
    import adcif_pkg::*;
#(
    parameter logic [5:0] DEV = ADC_DEV_CODE
) (
    input  logic       strb,
    input  logic [5:0] dev,
    input  logic [2:0] op,
    input  logic [1:0] fn,
    output cmd_t       cmd
);
    logic hit;

    always_comb begin
        hit           = strb && (dev == DEV);
        cmd.load_chan = hit && (io_op_e'(op) == OP_DOA);
        cmd.rd_chan   = hit && (io_op_e'(op) == OP_DIA);
        cmd.rd_data   = hit && (io_op_e'(op) == OP_DIC);
        cmd.start     = hit && (io_fn_e'(fn) == FN_START);
        cmd.clear     = hit && (io_fn_e'(fn) == FN_CLEAR);
    end

endmodule

// File: rtl/adcif_gate.sv
module adcif_gate #(
    parameter int TB_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            int_en,
    input  logic [TB_W-1:0] div,
    input  logic            ext_en,
    input  logic            ext_clk,
    output logic            gate_ok
);
    logic [TB_W-1:0] cnt;
    logic [TB_W-1:0] lim;
    logic            tick;
    logic [2:0]      sync;
    logic            rise;

    always_comb begin
        lim  = (div == '0) ? '0 : div - 1'b1;
        tick = (cnt >= lim);
        rise = sync[1] && !sync[2];
        if (int_en)      gate_ok = tick;
        else if (ext_en) gate_ok = rise;
        else             gate_ok = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            sync <= '0;
        end else begin
            cnt  <= tick ? '0 : cnt + 1'b1;
            sync <= {sync[1:0], ext_clk};
        end
    end

    // R10: after a tick the counter restarts, so no tick follows unless the period is one
    a_r10_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && lim != '0) |=> (!tick || lim == '0));

    // R11: a detected external edge lasts one cycle
    a_r11_edge_single: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/adc_pio_ctrl.sv
module adc_pio_ctrl
    import adcif_pkg::*;
#(
    parameter int         TB_W = 24,
    parameter logic [5:0] DEV  = ADC_DEV_CODE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            io_strb,
    input  logic [5:0]      io_dev,
    input  logic [2:0]      io_op,
    input  logic [1:0]      io_fn,
    input  logic [15:0]     io_wdata,
    output logic [15:0]     io_rdata,
    input  logic            msk_strb,
    output logic            int_req,
    output logic            skp_idle,
    output logic            skp_done,
    input  logic            tb_int_en,
    input  logic [TB_W-1:0] tb_div,
    input  logic            tb_ext_en,
    input  logic            tb_ext_clk,
    output logic            cv_start,
    input  logic            cv_eoc,
    input  logic [15:0]     cv_data
);
    cmd_t        cmd;
    logic        gate_ok;
    logic [7:0]  chan;
    logic [15:0] result;
    logic        busy;
    logic        done;
    logic        launched;
    logic        masked;
    logic        eoc_ok;

    adcif_decode #(.DEV(DEV)) u_dec (
        .strb (io_strb),
        .dev  (io_dev),
        .op   (io_op),
        .fn   (io_fn),
        .cmd  (cmd)
    );

    adcif_gate #(.TB_W(TB_W)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .int_en  (tb_int_en),
        .div     (tb_div),
        .ext_en  (tb_ext_en),
        .ext_clk (tb_ext_clk),
        .gate_ok (gate_ok)
    );

    assign eoc_ok = cv_eoc && launched;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan     <= '0;
            result   <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            launched <= 1'b0;
            masked   <= 1'b0;
            cv_start <= 1'b0;
        end else begin
            cv_start <= 1'b0;
            if (busy && !launched && gate_ok) begin
                launched <= 1'b1;
                cv_start <= 1'b1;
            end
            if (eoc_ok) begin
                busy     <= 1'b0;
                done     <= 1'b1;
                launched <= 1'b0;
                result   <= cv_data;
                chan     <= chan + 1'b1;
            end
            if (cmd.load_chan)
                chan <= io_wdata[7:0];
            if (cmd.start && !busy) begin
                busy <= 1'b1;
                done <= 1'b0;
            end
            if (cmd.clear) begin
                busy     <= 1'b0;
                done     <= 1'b0;
                launched <= 1'b0;
                cv_start <= 1'b0;
            end
            if (msk_strb)
                masked <= io_wdata[MASK_BIT];
        end
    end

    always_comb begin
        io_rdata = '0;
        if (cmd.rd_chan)      io_rdata = chan_word(chan);
        else if (cmd.rd_data) io_rdata = result;
        int_req  = done && !masked;
        skp_idle = !busy;
        skp_done = done;
    end

    // R2: a data-out A leaves the low accumulator byte in the channel register
    a_r2_chan_load: assert property (@(posedge clk) disable iff (rst)
        cmd.load_chan |=> (chan == $past(io_wdata[7:0])));

    // R4: an accepted Start leaves Busy set and Done clear
    a_r4_start_flags: assert property (@(posedge clk) disable iff (rst)
        (cmd.start && !busy && !cmd.clear) |=> (busy && !done));

    // R5: the converter start is a single-cycle pulse
    a_r5_start_pulse: assert property (@(posedge clk) disable iff (rst)
        cv_start |=> !cv_start);

    // R5: a Start during Busy does not drop Busy
    a_r5_busy_start: assert property (@(posedge clk) disable iff (rst)
        (cmd.start && busy && !cmd.clear && !eoc_ok) |=> busy);

    // R6: Clear empties both flags
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> (!busy && !done));

    // R7: an accepted end of conversion completes the cycle
    a_r7_eoc_done: assert property (@(posedge clk) disable iff (rst)
        (eoc_ok && !cmd.clear) |=> (done && !busy));

endmodule

// File: tb/sim_adc_pio_ctrl.sv
module sim_adc_pio_ctrl;
    localparam int TB_W = 24;
    localparam int LAT  = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            io_strb = 1'b0;
    logic [5:0]      io_dev = '0;
    logic [2:0]      io_op = '0;
    logic [1:0]      io_fn = '0;
    logic [15:0]     io_wdata = '0;
    logic [15:0]     io_rdata;
    logic            msk_strb = 1'b0;
    logic            int_req, skp_idle, skp_done, cv_start;
    logic            tb_int_en = 1'b0;
    logic [TB_W-1:0] tb_div = '0;
    logic            tb_ext_en = 1'b0;
    logic            tb_ext_clk = 1'b0;
    logic            model_eoc = 1'b0;
    logic            cv_eoc;
    logic [15:0]     cv_data = '0;

    assign cv_eoc = model_eoc;

    adc_pio_ctrl #(.TB_W(TB_W)) u0 (
        .clk(clk), .rst(rst), .io_strb(io_strb), .io_dev(io_dev), .io_op(io_op),
        .io_fn(io_fn), .io_wdata(io_wdata), .io_rdata(io_rdata), .msk_strb(msk_strb),
        .int_req(int_req), .skp_idle(skp_idle), .skp_done(skp_done),
        .tb_int_en(tb_int_en), .tb_div(tb_div), .tb_ext_en(tb_ext_en),
        .tb_ext_clk(tb_ext_clk), .cv_start(cv_start), .cv_eoc(cv_eoc), .cv_data(cv_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_starts = 0;
    int last_start = 0;
    int model_k = 0;
    int exp_q[$];
    logic [15:0] rd;

    function automatic logic [15:0] sample(input int k);
        return 16'(k * 16'h1357) ^ 16'h8000;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one instruction cycle; called and returning on a falling edge
    task automatic io(input logic [5:0] dev, input logic [2:0] op,
                      input logic [1:0] fn, input logic [15:0] wd);
        io_strb = 1'b1; io_dev = dev; io_op = op; io_fn = fn; io_wdata = wd;
        #1 rd = io_rdata;
        @(negedge clk);
        io_strb = 1'b0; io_op = '0; io_fn = '0;
    endtask

    // driver: an accepted Start pushes one expected launch into the scoreboard
    task automatic start_conv();
        exp_q.push_back(model_k);
        io(6'o21, 3'd0, 2'd1, 16'h0);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400 && !skp_done; i++) @(negedge clk);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // converter model
    initial begin
        forever begin
            @(negedge clk);
            if (cv_start) begin
                repeat (LAT - 1) @(negedge clk);
                model_eoc = 1'b1;
                cv_data = sample(model_k);
                @(negedge clk);
                model_eoc = 1'b0;
                model_k++;
            end
        end
    end

    // monitor: every launch must match an expected one
    initial begin
        forever begin
            @(negedge clk);
            if (cv_start) begin
                n_starts++;
                last_start = cyc;
                if (exp_q.size() == 0)
                    check(1'b0, "R5 unexpected launch", 1, 0);
                else
                    check(exp_q.pop_front() == model_k, "R4 launch order", model_k, model_k);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t1;
        int n0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        check(skp_idle && !skp_done && !int_req && !cv_start, "R9 reset flags",
              {skp_idle, skp_done, int_req, cv_start}, 4'b1000);
        io(6'o21, 3'd1, 2'd0, 16'h0);
        check(rd == 16'h0000, "R2 reset channel", rd, 0);

        // R1: foreign device code
        io(6'o22, 3'd2, 2'd1, 16'h0055);
        io(6'o22, 3'd1, 2'd0, 16'h0);
        check(rd == 16'h0000, "R1 foreign read", rd, 0);
        io(6'o21, 3'd1, 2'd0, 16'h0);
        check(rd == 16'h0000, "R1 foreign write ignored", rd, 0);
        repeat (3) @(negedge clk);
        check(skp_idle && n_starts == 0, "R1 foreign start ignored", n_starts, 0);

        // R2: upper byte ignored
        io(6'o21, 3'd2, 2'd0, 16'h01FE);
        io(6'o21, 3'd1, 2'd0, 16'h0);
        check(rd == 16'h00FE, "R2 channel readback", rd, 16'h00FE);

        // R4: start
        start_conv();
        check(!skp_idle && !skp_done, "R4 busy after start", {skp_idle, skp_done}, 0);
        @(negedge clk);
        check(cv_start == 1'b1, "R4 launch pulse", cv_start, 1);
        // R5: start during busy
        io(6'o21, 3'd0, 2'd1, 16'h0);
        check(!skp_idle, "R5 still busy", skp_idle, 0);
        wait_done();
        check(skp_done && skp_idle, "R7 done set busy clear", {skp_done, skp_idle}, 2'b11);
        check(int_req, "R8 request with mask clear", int_req, 1);
        io(6'o21, 3'd1, 2'd0, 16'h0);
        check(rd == 16'h00FF, "R7 channel increment", rd, 16'h00FF);
        io(6'o21, 3'd5, 2'd0, 16'h0);
        check(rd == sample(0), "R3 sample readback", rd, sample(0));
        check(n_starts == 1, "R5 single launch", n_starts, 1);

        // R7: wrap 255 -> 0
        start_conv();
        wait_done();
        io(6'o21, 3'd1, 2'd0, 16'h0);
        check(rd == 16'h0000, "R7 channel wrap", rd, 0);
        io(6'o21, 3'd5, 2'd0, 16'h0);
        check(rd == sample(1), "R3 second sample", rd, sample(1));

        // R8: mask
        msk_strb = 1'b1; io_wdata = 16'h0080;
        @(negedge clk);
        msk_strb = 1'b0;
        check(!int_req && skp_done, "R8 masked request", int_req, 0);
        msk_strb = 1'b1; io_wdata = 16'hFF7F;
        @(negedge clk);
        msk_strb = 1'b0;
        check(int_req, "R8 unmasked request", int_req, 1);

        // R6: clear
        io(6'o21, 3'd0, 2'd2, 16'h0);
        check(!skp_done && skp_idle && !int_req, "R6 clear flags", {skp_done, skp_idle, int_req}, 3'b010);
        io(6'o21, 3'd5, 2'd0, 16'h0);
        check(rd == sample(1), "R3 sample held after clear", rd, sample(1));

        // R6: clear while a conversion is in flight
        start_conv();
        @(negedge clk);
        io(6'o21, 3'd0, 2'd2, 16'h0);
        repeat (LAT + 4) @(negedge clk);
        check(!skp_done && skp_idle, "R6 late strobe ignored", {skp_done, skp_idle}, 2'b01);
        io(6'o21, 3'd1, 2'd0, 16'h0);
        check(rd == 16'h0000, "R6 channel unchanged", rd, 0);
        io(6'o21, 3'd5, 2'd0, 16'h0);
        check(rd == sample(1), "R6 sample unchanged", rd, sample(1));

        // R10: internal timebase spacing
        tb_div = 24'd40; tb_int_en = 1'b1;
        start_conv();
        wait_done();
        t1 = last_start;
        start_conv();
        wait_done();
        check(last_start - t1 == 40, "R10 tick spacing", last_start - t1, 40);
        io(6'o21, 3'd5, 2'd0, 16'h0);
        check(rd == sample(model_k - 1), "R3 timebase sample", rd, sample(model_k - 1));

        // R11: external clock
        tb_int_en = 1'b0; tb_ext_en = 1'b1;
        n0 = n_starts;
        start_conv();
        repeat (30) @(negedge clk);
        check(n_starts == n0 && !skp_idle, "R11 waits for edge", n_starts, n0);
        tb_ext_clk = 1'b1;
        repeat (4) @(negedge clk);
        check(n_starts == n0 + 1, "R11 launch after edge", n_starts, n0 + 1);
        wait_done();
        check(skp_done, "R11 conversion completes", skp_done, 1);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R4 all expected launches seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule